// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder/Subtractor

This unit adds or subtracts two 32-bit floating-point words taken from an operand stack. The first input holds the next-on-stack value and the second holds the top-of-stack value. With the operation select low it produces next plus top. With it high it produces next minus top. The result then replaces the next-on-stack entry. Each word has a sign in bit 31 (1 is negative), an 8-bit exponent in bits 30..23 biased by 127, and a 23-bit fraction in bits 22..0. The arithmetic adds a hidden leading one above bit 22.

One start pulse captures both operands. The unit brings the smaller operand into line with the larger one, one bit position per clock, so the latency depends on the exponent difference. It then adds the magnitudes, renormalises, rounds to nearest-even and packs the word. A one-cycle done pulse marks the cycle in which the result and a 4-bit flag word are first valid. Both hold until the next operation completes. Results outside the exponent range saturate and raise a flag; they are never encoded as special values.

Top module: `spfAddUnit`

## Requirements
- R1: An operand whose exponent field is 0 counts as zero, whatever its fraction bits hold. Any other operand has the value 1.fraction x 2^(exponent-127).
- R2: With opSub=0 the result is nosIn + tosIn, correctly rounded. For example, 0x3F800000 + 0x3F800000 gives 0x40000000.
- R3: With opSub=1 the result is nosIn - tosIn, correctly rounded. For example, 0x40000000 - 0x3F800000 gives 0x3F800000.
- R4: Rounding is to nearest, and an exact tie goes to the even fraction. So 0x3F800000 + 0x33800000 gives 0x3F800000, and 0x3F800001 + 0x33800000 gives 0x3F800002.
- R5: An exactly zero sum gives 0x00000000 (positive sign) with flags[0] (zero) set. For example, 0x3F800000 - 0x3F800000.
- R6: If the rounded exponent would reach 255 or more, the result saturates to the largest magnitude of the correct sign (exponent field 0xFE, fraction all ones) and flags[2] (overflow) is set. This includes a carry out of rounding.
- R7: If the normalised exponent would be 0 or less, the result is 0x00000000 and both flags[3] (underflow) and flags[0] (zero) are set.
- R8: flags[1] (sign) equals bit 31 of the result. flags[0] is set exactly when the result is 0x00000000. Overflow and underflow are never set together.
- R9: done is high for exactly one cycle per accepted start. Between done pulses, result and flags do not change.
- R10: A start asserted while an operation is in progress is ignored. So are changes on nosIn, tosIn and opSub during that time. The running operation finishes with its own operands, and no extra done appears.
- R11: Alignment moves one bit per cycle. Let d be the exponent difference when both operands are non-zero, and 0 otherwise. Counting clock edges from the edge that accepts start, done first appears after d+4 to d+30 edges.
- R12: After reset, result, flags and done are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation when idle |
| opSub | input | 1 | 0: next + top, 1: next - top |
| nosIn | input | 32 | Next-on-stack operand |
| tosIn | input | 32 | Top-of-stack operand |
| result | output | 32 | Packed rounded result |
| flags | output | 4 | {underflow, overflow, sign, zero} |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions check several properties on every cycle. The aligned operand never overtakes the larger exponent. Rounding only starts on a normalised sum. Overflow and underflow never appear together, and the sign flag tracks the packed sign. done is a single-cycle pulse, and outputs stay frozen outside the rounding step. Only the bench scenarios can show that the rounded values are numerically right. That covers ties to even, rounding carries into overflow, deep cancellation into underflow, zero-exponent operands, and the exponent-dependent latency window. The bench compares each result against an exact wide-integer model.

// File: rtl/spfAddPkg.sv
package spfAddPkg;

  // control -> datapath strobes
  typedef struct packed {
    logic load;
    logic alignShift;
    logic addStep;
    logic normRight;
    logic normLeft;
    logic roundStep;
  } spfStrobe_t;

  // datapath -> control observations
  typedef struct packed {
    logic needShift;
    logic sumZero;
    logic sumCarry;
    logic sumNorm;
  } spfStat_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ALIGN,
    ST_ADD,
    ST_NORM,
    ST_ROUND
  } spfState_t;

  localparam int FLAG_ZERO = 0;
  localparam int FLAG_SIGN = 1;
  localparam int FLAG_OVF  = 2;
  localparam int FLAG_UNF  = 3;
  localparam int FLAG_W    = 4;

endpackage

// File: rtl/spfAddCtrl.sv
module spfAddCtrl
  import spfAddPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  spfStat_t   stat,
  output spfStrobe_t strobe,
  output logic       done
);

  spfState_t state, nextState;

  always_comb begin
    strobe    = '0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (start) begin
          strobe.load = 1'b1;
          nextState   = ST_ALIGN;
        end
      end
      ST_ALIGN: begin
        if (stat.needShift) strobe.alignShift = 1'b1;
        else                nextState         = ST_ADD;
      end
      ST_ADD: begin
        strobe.addStep = 1'b1;
        nextState      = ST_NORM;
      end
      ST_NORM: begin
        if (stat.sumZero) begin
          nextState = ST_ROUND;
        end else if (stat.sumCarry) begin
          strobe.normRight = 1'b1;
          nextState        = ST_ROUND;
        end else if (!stat.sumNorm) begin
          strobe.normLeft = 1'b1;
        end else begin
          nextState = ST_ROUND;
        end
      end
      ST_ROUND: begin
        strobe.roundStep = 1'b1;
        nextState        = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= nextState;
      done  <= strobe.roundStep;
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (state == ST_IDLE));

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe));

endmodule

// File: rtl/spfAddPath.sv
module spfAddPath
  import spfAddPkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
)(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    opSub,
  input  logic [EXP_W+FRAC_W:0]   nosIn,
  input  logic [EXP_W+FRAC_W:0]   tosIn,
  input  spfStrobe_t              strobe,
  output spfStat_t                stat,
  output logic [EXP_W+FRAC_W:0]   result,
  output logic [FLAG_W-1:0]       flags
);

  localparam int WORD_W   = EXP_W + FRAC_W + 1;
  localparam int SIGN_POS = WORD_W - 1;
  localparam int MAN_W    = FRAC_W + 1;
  localparam int EXT_W    = MAN_W + 3;
  localparam int SEXP_W   = EXP_W + 2;
  localparam logic [EXP_W-1:0] EXP_TOP = '1;
  localparam logic [EXP_W-1:0] EXP_MAX = EXP_TOP - 1'b1;

  // operand unpacking
  logic [EXP_W-1:0] nosExp, tosExp;
  logic [EXT_W-1:0] nosMan, tosMan;
  logic             nosSign, tosSign, swapIn;

  assign nosExp  = nosIn[WORD_W-2 -: EXP_W];
  assign tosExp  = tosIn[WORD_W-2 -: EXP_W];
  assign nosSign = nosIn[SIGN_POS];
  assign tosSign = tosIn[SIGN_POS] ^ opSub;
  assign nosMan  = (nosExp == '0) ? '0 : {1'b1, nosIn[FRAC_W-1:0], 3'b000};
  assign tosMan  = (tosExp == '0) ? '0 : {1'b1, tosIn[FRAC_W-1:0], 3'b000};
  assign swapIn  = tosExp > nosExp;

  // working registers: A holds the larger exponent
  logic [EXP_W-1:0]         expA, expB;
  logic [EXT_W-1:0]         manA, manB;
  logic                     signA, signB;
  logic [EXT_W:0]           sum;
  logic                     sumSign;
  logic signed [SEXP_W-1:0] sumExp;

  // magnitude adder
  logic [EXT_W:0] addRaw;
  logic           addSign;

  always_comb begin
    if (signA == signB) begin
      addRaw  = {1'b0, manA} + {1'b0, manB};
      addSign = signA;
    end else if (manA >= manB) begin
      addRaw  = {1'b0, manA - manB};
      addSign = signA;
    end else begin
      addRaw  = {1'b0, manB - manA};
      addSign = signB;
    end
  end

  // rounding and packing
  logic [MAN_W-1:0]         keepMan;
  logic                     guardB, roundB, stickyB, roundUp;
  logic [MAN_W:0]           roundedMan;
  logic signed [SEXP_W-1:0] finExp;
  logic [FRAC_W-1:0]        finFrac;
  logic                     isOvf, isUnf;
  logic [WORD_W-1:0]        resNext;
  logic [FLAG_W-1:0]        flagNext;

  always_comb begin
    keepMan    = sum[EXT_W-1:3];
    guardB     = sum[2];
    roundB     = sum[1];
    stickyB    = sum[0];
    roundUp    = guardB & (roundB | stickyB | keepMan[0]);
    roundedMan = {1'b0, keepMan} + {{MAN_W{1'b0}}, roundUp};
    finExp     = sumExp + $signed({{(SEXP_W-1){1'b0}}, roundedMan[MAN_W]});
    finFrac    = roundedMan[MAN_W] ? roundedMan[FRAC_W:1] : roundedMan[FRAC_W-1:0];
    isOvf      = finExp > $signed({2'b00, EXP_MAX});
    isUnf      = finExp <= SEXP_W'(0);

    resNext            = {sumSign, finExp[EXP_W-1:0], finFrac};
    flagNext           = '0;
    flagNext[FLAG_SIGN] = sumSign;
    if (stat.sumZero) begin
      resNext             = '0;
      flagNext            = '0;
      flagNext[FLAG_ZERO] = 1'b1;
    end else if (isOvf) begin
      resNext            = {sumSign, EXP_MAX, {FRAC_W{1'b1}}};
      flagNext[FLAG_OVF] = 1'b1;
    end else if (isUnf) begin
      resNext             = '0;
      flagNext            = '0;
      flagNext[FLAG_UNF]  = 1'b1;
      flagNext[FLAG_ZERO] = 1'b1;
    end
  end

  assign stat.needShift = (expB != expA) && (manB != '0);
  assign stat.sumZero   = (sum == '0);
  assign stat.sumCarry  = sum[EXT_W];
  assign stat.sumNorm   = sum[EXT_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      expA    <= '0;
      expB    <= '0;
      manA    <= '0;
      manB    <= '0;
      signA   <= 1'b0;
      signB   <= 1'b0;
      sum     <= '0;
      sumSign <= 1'b0;
      sumExp  <= '0;
      result  <= '0;
      flags   <= '0;
    end else begin
      if (strobe.load) begin
        if (swapIn) begin
          expA <= tosExp;  manA <= tosMan;  signA <= tosSign;
          expB <= nosExp;  manB <= nosMan;  signB <= nosSign;
        end else begin
          expA <= nosExp;  manA <= nosMan;  signA <= nosSign;
          expB <= tosExp;  manB <= tosMan;  signB <= tosSign;
        end
      end
      if (strobe.alignShift) begin
        manB <= {1'b0, manB[EXT_W-1:2], manB[1] | manB[0]};
        expB <= expB + 1'b1;
      end
      if (strobe.addStep) begin
        sum     <= addRaw;
        sumSign <= addSign;
        sumExp  <= $signed({2'b00, expA});
      end
      if (strobe.normRight) begin
        sum    <= {1'b0, sum[EXT_W:2], sum[1] | sum[0]};
        sumExp <= sumExp + SEXP_W'(1);
      end
      if (strobe.normLeft) begin
        sum    <= {sum[EXT_W-1:0], 1'b0};
        sumExp <= sumExp - SEXP_W'(1);
      end
      if (strobe.roundStep) begin
        result <= resNext;
        flags  <= flagNext;
      end
    end
  end

  // R11
  align_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    expB <= expA);

  // R4
  round_norm_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.roundStep && !stat.sumZero) |-> (sum[EXT_W-1] && !sum[EXT_W]));

  // R8
  range_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(flags[FLAG_OVF] && flags[FLAG_UNF]));

  // R8
  sign_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    flags[FLAG_SIGN] == result[SIGN_POS]);

  // R9
  hold_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.roundStep |=> ($stable(result) && $stable(flags)));

endmodule

// File: rtl/spfAddUnit.sv
module spfAddUnit
  import spfAddPkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
)(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic                  opSub,
  input  logic [EXP_W+FRAC_W:0] nosIn,
  input  logic [EXP_W+FRAC_W:0] tosIn,
  output logic [EXP_W+FRAC_W:0] result,
  output logic [FLAG_W-1:0]     flags,
  output logic                  done
);

  spfStrobe_t strobe;
  spfStat_t   stat;

  spfAddCtrl uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .stat   (stat),
    .strobe (strobe),
    .done   (done)
  );

  spfAddPath #(
    .EXP_W  (EXP_W),
    .FRAC_W (FRAC_W)
  ) uPath (
    .clk    (clk),
    .rstN   (rstN),
    .opSub  (opSub),
    .nosIn  (nosIn),
    .tosIn  (tosIn),
    .strobe (strobe),
    .stat   (stat),
    .result (result),
    .flags  (flags)
  );

endmodule

// File: tb/spfAddUnit_test.sv
`timescale 1ns/1ps
module spfAddUnit_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        opSub = 1'b0;
  logic [31:0] nosIn = '0;
  logic [31:0] tosIn = '0;
  logic [31:0] result;
  logic [3:0]  flags;
  logic        done;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit pending = 1'b0;
  logic [31:0] prevRes = '0;
  logic [3:0]  prevFlags = '0;
  logic        prevDone = 1'b0;

  spfAddUnit uut (
    .clk(clk), .rstN(rstN), .start(start), .opSub(opSub),
    .nosIn(nosIn), .tosIn(tosIn), .result(result), .flags(flags), .done(done)
  );

  always #2 clk = ~clk;

  task automatic checkVal(input string req, input string what,
                          input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // exact behavioural model: {unf, ovf, sign, zero, result}
  function automatic logic [35:0] refModel(input logic [31:0] a, input logic [31:0] b,
                                           input logic sub);
    logic [299:0] ma, mb, mag;
    logic sa, sb, sr, half, rest;
    logic [24:0] m;
    int p, e, sh;
    ma = '0;
    mb = '0;
    if (a[30:23] != 8'd0) begin
      ma = {276'd0, 1'b1, a[22:0]};
      ma = ma << (int'(a[30:23]) - 1);
    end
    if (b[30:23] != 8'd0) begin
      mb = {276'd0, 1'b1, b[22:0]};
      mb = mb << (int'(b[30:23]) - 1);
    end
    sa = a[31];
    sb = b[31] ^ sub;
    if (sa == sb) begin mag = ma + mb; sr = sa; end
    else if (ma >= mb) begin mag = ma - mb; sr = sa; end
    else begin mag = mb - ma; sr = sb; end
    if (mag == '0) return {4'b0001, 32'h0};
    p = 0;
    for (int i = 0; i < 300; i++) if (mag[i]) p = i;
    e = p - 22;
    if (p > 23) begin
      sh = p - 23;
      m = mag[sh +: 25];
      half = mag[sh-1];
      rest = ((mag << (301 - sh)) != '0);
      if (half && (rest || m[0])) m = m + 25'd1;
      if (m[24]) begin m = m >> 1; e = e + 1; end
    end else begin
      m = 25'(mag << (23 - p));
    end
    if (e >= 255) return {1'b0, 1'b1, sr, 1'b0, sr, 8'hFE, 23'h7FFFFF};
    if (e <= 0) return {4'b1001, 32'h0};
    return {1'b0, 1'b0, sr, 1'b0, sr, 8'(e), m[22:0]};
  endfunction

  // every-clock comparison of the handshake and output hold
  always @(negedge clk) begin
    #1;
    if (rstN) begin
      if (done) begin
        checkVal("R9", "done without pending op", 64'(pending), 64'd1);
        checkVal("R9", "done longer than one cycle", 64'(prevDone), 64'd0);
      end else begin
        checkVal("R9", "outputs held", {28'd0, prevFlags, prevRes}, {28'd0, flags, result});
      end
    end
    prevRes = result;
    prevFlags = flags;
    prevDone = done;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      compared++;
      mismatched++;
      $display("FAIL R11 watchdog actual=%0d expected=<150000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic runOp(input logic [31:0] a, input logic [31:0] b, input logic sub,
                       input string req, input bit busyPoke);
    logic [35:0] exp;
    int k, d, ea, eb;
    exp = refModel(a, b, sub);
    ea = int'(a[30:23]);
    eb = int'(b[30:23]);
    d = (ea != 0 && eb != 0) ? ((ea > eb) ? ea - eb : eb - ea) : 0;
    @(negedge clk);
    nosIn = a; tosIn = b; opSub = sub; start = 1'b1; pending = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = 0;
    while (!done && k < 400) begin
      if (busyPoke && k == 1) begin
        nosIn = ~a; tosIn = 32'h3F800000; opSub = ~sub; start = 1'b1;   // R10
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      k++;
    end
    start = 1'b0;
    checkVal(req, "result", 64'(result), 64'(exp[31:0]));
    checkVal(req, "flags", 64'(flags), 64'(exp[35:32]));
    compared++;
    if (k < d + 4 || k > d + 30) begin   // R11 latency window
      mismatched++;
      $display("FAIL R11 latency actual=%0d expected=%0d..%0d", k, d + 4, d + 30);
    end
    @(negedge clk);
    pending = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R12 reset state
    checkVal("R12", "reset outputs", {31'd0, done, flags, result}, 64'd0);

    runOp(32'h3F800000, 32'h3F800000, 1'b0, "R2", 1'b0);
    runOp(32'h40490FDB, 32'hC0000000, 1'b0, "R2", 1'b0);
    runOp(32'h3F800000, 32'h3F800000, 1'b1, "R5", 1'b0);
    runOp(32'h40000000, 32'h3F800000, 1'b1, "R3", 1'b0);
    runOp(32'h3F800000, 32'h40000000, 1'b1, "R3", 1'b0);
    runOp(32'hC1200000, 32'h3F000000, 1'b1, "R8", 1'b0);
    runOp(32'h00000000, 32'h40490FDB, 1'b0, "R1", 1'b0);
    runOp(32'h007FFFFF, 32'h3F800000, 1'b0, "R1", 1'b0);
    runOp(32'h00000000, 32'h80000000, 1'b1, "R5", 1'b0);
    runOp(32'h3F800000, 32'h33800000, 1'b0, "R4", 1'b0);
    runOp(32'h3F800001, 32'h33800000, 1'b0, "R4", 1'b0);
    runOp(32'h3F800000, 32'h33800001, 1'b0, "R4", 1'b0);
    runOp(32'h3F800000, 32'h00800000, 1'b0, "R11", 1'b0);
    runOp(32'h3F800001, 32'h3F800000, 1'b1, "R3", 1'b0);
    runOp(32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, "R6", 1'b0);
    runOp(32'hFF7FFFFF, 32'h7F7FFFFF, 1'b1, "R6", 1'b0);
    runOp(32'h7F7FFFFF, 32'h73000000, 1'b0, "R6", 1'b0);
    runOp(32'h00800001, 32'h00800000, 1'b1, "R7", 1'b0);
    runOp(32'h00C00000, 32'h00800001, 1'b1, "R7", 1'b0);
    runOp(32'h40400000, 32'h3FC00000, 1'b0, "R10", 1'b1);
    runOp(32'h3F800000, 32'h3F800000, 1'b1, "R10", 1'b1);

    for (int n = 0; n < 60; n++) begin
      logic [31:0] a, b;
      logic [7:0] ea;
      ea = 8'(100 + ($urandom % 55));
      a = {1'($urandom), ea, 23'($urandom)};
      if (n % 2 == 0) b = {1'($urandom), 8'(int'(ea) + int'($urandom % 3) - 1), 23'($urandom)};
      else            b = {1'($urandom), 8'(100 + ($urandom % 55)), 23'($urandom)};
      runOp(a, b, 1'($urandom), (n % 2 == 0) ? "R3" : "R2", 1'b0);
    end

    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule